// File: doc/BRIEF.md
# Hysteretic Coolant Flow Setting Selector

The block turns a stream of forecast peak die temperatures into a choice among a few discrete coolant pump flow settings. Each time a forecast arrives, it is compared with a small table of temperature boundaries. Boundary k separates setting k from setting k+1, and a higher setting gives more flow. The selector raises the flow at once, jumping straight to the setting the forecast demands. It lowers the flow only one step at a time, and only when the forecast has fallen a fixed margin below the boundary that led to the current setting. This avoids dithering between two settings.

After every change of setting, the pump needs time to reach its new rate. A programmable settle window therefore follows each change. Forecasts that arrive inside the window do not act on the output, but the most recent one is kept. That value is evaluated when the window closes. Software loads the boundaries and the window length through an address/data write port. The selector drives a registered setting index and a one-cycle strobe on each change.

Temperatures are unsigned 8-bit codes in steps of 0.25 °C. The default down-step margin is 8 codes, which is 2 °C.

Top module: `coolant_flow_sel`

## Requirements
- R1: While and after reset, `flow_lvl` is the highest setting (4) and `flow_chg` is 0.
- R2: An evaluated forecast that is strictly greater than boundary k, where k is the highest such boundary, selects setting k+1 whenever k+1 exceeds the current setting. The new setting appears on the first clock edge that samples the forecast.
- R3: From a current setting c > 0, the selector steps down only when forecast + 8 <= boundary c-1. A forecast inside that margin leaves the setting unchanged.
- R4: A downward change is always exactly one setting per evaluation.
- R5: `flow_chg` is high for exactly one cycle, in the cycle after the edge at which `flow_lvl` changes, and at no other time.
- R6: After a change, the settle register length L blocks decisions for L cycles. Forecasts sampled at the L-1 edges that follow the change leave `flow_lvl` unchanged.
- R7: At the L-th edge after a change, the most recent forecast is evaluated. A new forecast sampled at that same edge takes precedence. A length of 0 disables the window.
- R8: Write addresses 0 to 3 load boundaries 0 to 3 from `cfg_wdata[7:0]`. Address 4 loads the settle length from `cfg_wdata`. Writes to addresses 5 to 7 change nothing.
- R9: A forecast equal to a boundary does not count as crossing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Forecast strobe, one cycle per forecast |
| smp_temp | input | 8 | Forecast peak temperature, 0.25 °C per code |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration address (0-3 boundaries, 4 settle length) |
| cfg_wdata | input | 32 | Configuration write data |
| flow_lvl | output | 3 | Selected flow setting index, 0 lowest |
| flow_chg | output | 1 | One-cycle strobe on a setting change |

## Verification
Two functions can fall on the same clock edge: the expiry of the settle window, which re-evaluates the stored forecast, and the arrival of a fresh forecast. The bench places a fresh forecast exactly on the expiry edge. The stored value would hold the setting one step down, while the fresh value demands the top setting. The outcome must be the top setting with a strobe, which shows that the fresh value won. The bench also checks the edges just before expiry, where forecasts must be dropped, and the expiry edge with no new input, where the stored value must act.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/fsel_table.sv
module fsel_table #(
  parameter int TW = 8,
  parameter int NB = 4,
  parameter int AW = 3,
  parameter int SW = 32,
  parameter logic [NB*TW-1:0] BND_RST = '0,
  parameter logic [SW-1:0] SETTLE_RST = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [SW-1:0]   wdata,
  output logic [NB*TW-1:0] bnd_flat,
  output logic [SW-1:0]   settle_len
);
  logic [TW-1:0] bnd_q [NB];

  for (genvar k = 0; k < NB; k++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (rst) bnd_q[k] <= BND_RST[k*TW +: TW];
      else if (we && addr == AW'(k)) bnd_q[k] <= wdata[TW-1:0];
    end
    assign bnd_flat[k*TW +: TW] = bnd_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) settle_len <= SETTLE_RST;
    else if (we && addr == AW'(NB)) settle_len <= wdata;
  end
endmodule

// File: rtl/fsel_decide.sv
module fsel_decide
  import fsel_pkg::*;
#(
  parameter int TW   = 8,
  parameter int NB   = 4,
  parameter int LW   = 3,
  parameter int HYST = 8
) (
  input  logic [TW-1:0]    temp,
  input  logic [NB*TW-1:0] bnd_flat,
  input  logic [LW-1:0]    cur,
  output logic [LW-1:0]    nxt,
  output step_e            kind
);
  localparam int CW = TW + 2;

  logic [LW-1:0] up_tgt;
  logic [TW-1:0] below_bnd;
  logic [CW-1:0] temp_plus;

  always_comb begin
    up_tgt    = '0;
    below_bnd = '0;
    for (int k = 0; k < NB; k++) begin
      if (temp > bnd_flat[k*TW +: TW]) up_tgt = LW'(k + 1);
      if (cur == LW'(k + 1)) below_bnd = bnd_flat[k*TW +: TW];
    end
  end

  assign temp_plus = CW'(temp) + CW'(HYST);

  always_comb begin
    nxt  = cur;
    kind = STEP_HOLD;
    if (up_tgt > cur) begin
      nxt  = up_tgt;
      kind = STEP_UP;
    end else if (cur != '0 && temp_plus <= CW'(below_bnd)) begin
      nxt  = cur - LW'(1);
      kind = STEP_DOWN;
    end
  end
endmodule

// File: rtl/fsel_settle.sv
module fsel_settle #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] len,
  output logic          busy,
  output logic          last
);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - SW'(1);
  end

  assign busy = cnt_q != '0;
  assign last = cnt_q == SW'(1);

  assert_window_load_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(len)));
endmodule

// File: rtl/coolant_flow_sel.sv
module coolant_flow_sel
  import fsel_pkg::*;
#(
  parameter int NUM_SET = 5,
  parameter int TW      = 8,
  parameter int SW      = 32,
  parameter int HYST    = 8,
  parameter logic [SW-1:0] SETTLE_RST = 32'd30_000_000,
  parameter logic [(NUM_SET-1)*TW-1:0] BND_RST = {8'd200, 8'd160, 8'd120, 8'd80},
  parameter int NB_P    = NUM_SET - 1,
  parameter int LW_P    = $clog2(NUM_SET),
  parameter int AW_P    = $clog2(NUM_SET)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [TW-1:0]    smp_temp,
  input  logic             cfg_we,
  input  logic [AW_P-1:0]  cfg_addr,
  input  logic [SW-1:0]    cfg_wdata,
  output logic [LW_P-1:0]  flow_lvl,
  output logic             flow_chg
);
  localparam int NB = NB_P;
  localparam int LW = LW_P;
  localparam logic [LW-1:0] TOP_SET = LW'(NUM_SET - 1);

  logic [NB*TW-1:0] bnd_flat;
  logic [SW-1:0]    settle_len;
  logic [TW-1:0]    held_q;
  logic             have_q;
  logic             busy, last;
  logic             eval, change;
  logic [TW-1:0]    eval_temp;
  logic [LW-1:0]    nxt;
  step_e            kind;

  fsel_table #(.TW(TW), .NB(NB), .AW(AW_P), .SW(SW),
               .BND_RST(BND_RST), .SETTLE_RST(SETTLE_RST)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .bnd_flat(bnd_flat), .settle_len(settle_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      have_q <= 1'b0;
    end else if (smp_vld) begin
      held_q <= smp_temp;
      have_q <= 1'b1;
    end
  end

  assign eval      = (smp_vld && (!busy || last)) || (last && have_q);
  assign eval_temp = smp_vld ? smp_temp : held_q;

  fsel_decide #(.TW(TW), .NB(NB), .LW(LW), .HYST(HYST)) u_decide (
    .temp(eval_temp), .bnd_flat(bnd_flat), .cur(flow_lvl),
    .nxt(nxt), .kind(kind));

  assign change = eval && (kind != STEP_HOLD);

  fsel_settle #(.SW(SW)) u_settle (
    .clk(clk), .rst(rst), .load(change), .len(settle_len),
    .busy(busy), .last(last));

  always_ff @(posedge clk) begin
    if (rst) begin
      flow_lvl <= TOP_SET;
      flow_chg <= 1'b0;
    end else begin
      flow_chg <= change;
      if (change) flow_lvl <= nxt;
    end
  end

  assert_lvl_legal_R1: assert property (@(posedge clk) disable iff (rst)
    flow_lvl <= TOP_SET);

  assert_strobe_on_change_R5: assert property (@(posedge clk) disable iff (rst)
    flow_chg == (flow_lvl != $past(flow_lvl)));

  assert_down_one_step_R4: assert property (@(posedge clk) disable iff (rst)
    (flow_lvl < $past(flow_lvl)) |-> (flow_lvl == LW'($past(flow_lvl) - LW'(1))));

  assert_hold_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(flow_lvl));
endmodule

// File: tb/coolant_flow_sel_bench.sv
module coolant_flow_sel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld = 1'b0;
  logic [7:0]  smp_temp = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  flow_lvl;
  logic        flow_chg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coolant_flow_sel u_coolant_flow_sel (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_temp(smp_temp),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .flow_lvl(flow_lvl), .flow_chg(flow_chg));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cfg(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic smp(input int t);
    @(negedge clk);
    smp_vld = 1'b1; smp_temp = 8'(t);
    @(posedge clk); #1;
    smp_vld = 1'b0;
  endtask

  task automatic step(input int t, input int lvl, input int chg, input string tag);
    smp(t);
    chk({tag, " lvl"}, int'(flow_lvl), lvl);
    chk({tag, " chg"}, int'(flow_chg), chg);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    edges(3);
    chk("R1 reset lvl", int'(flow_lvl), 4);
    chk("R1 reset chg", int'(flow_chg), 0);
    @(negedge clk); rst = 1'b0;
    edges(1);
    chk("R1 after reset lvl", int'(flow_lvl), 4);
  endtask

  task automatic t_setup();
    cfg(0, 40); cfg(1, 80); cfg(2, 120); cfg(3, 160); cfg(4, 0);
  endtask

  task automatic t_down();
    step(170, 4, 0, "R2 stay top");
    step(100, 3, 1, "R4 one step");
    step(100, 2, 1, "R3 margin met");
    step(100, 2, 0, "R3 inside margin");
    step(72, 1, 1, "R3 margin exact");
    step(73, 1, 0, "R3 hold");
  endtask

  task automatic t_up_edge();
    step(161, 4, 1, "R2 jump");
    edges(1);
    chk("R5 strobe one cycle", int'(flow_chg), 0);
    step(160, 4, 0, "R9 equal top bound");
    step(0, 3, 1, "R4 d1");
    step(0, 2, 1, "R4 d2");
    step(0, 1, 1, "R4 d3");
    step(0, 0, 1, "R4 d4");
    step(40, 0, 0, "R9 equal bound0");
    step(41, 1, 1, "R2 just above");
  endtask

  task automatic t_window();
    cfg(4, 5);
    step(161, 4, 1, "R2 jump before window");
    step(0, 4, 0, "R6 drop1");
    step(100, 4, 0, "R6 drop2");
    edges(1);
    chk("R6 hold e3", int'(flow_lvl), 4);
    edges(1);
    chk("R6 hold e4", int'(flow_lvl), 4);
    edges(1);
    chk("R7 expiry lvl", int'(flow_lvl), 3);
    chk("R7 expiry chg", int'(flow_chg), 1);
    edges(4);
    chk("R6 hold second window", int'(flow_lvl), 3);
    step(200, 4, 1, "R7 fresh wins at expiry");
    edges(6);
    chk("R7 stable after", int'(flow_lvl), 4);
  endtask

  task automatic t_cfg();
    cfg(4, 0);
    step(0, 3, 1, "R8 z1");
    step(0, 2, 1, "R8 z2");
    step(0, 1, 1, "R8 z3");
    step(0, 0, 1, "R8 z4");
    cfg(6, 0);
    cfg(5, 0);
    cfg(7, 0);
    step(40, 0, 0, "R8 bad address ignored");
    cfg(0, 20);
    step(30, 1, 1, "R8 bound0 rewritten");
  endtask

  initial begin
    t_reset();
    t_setup();
    t_down();
    t_up_edge();
    t_window();
    t_cfg();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule